// File: doc/BRIEF.md
# Six-Byte Receive Frame Assembler

This block sits between a UART receive path and a memory write port. A bus controller reads received characters one at a time; each read places an 8-bit value on the block's input together with a chip-select strobe and a direction line. The block accepts a value only on a qualified read. It gathers six such bytes into one frame and splits the frame into a 16-bit address and a 32-bit data word.

When the sixth byte lands, the block raises a single ready flag. The memory side and the bus controller both watch this flag. While it is high, the address and data outputs hold still and further read strobes are ignored. The flag drops when the memory side returns an acknowledge. After that, collection starts again from the first byte. The field widths are parameters, and the frame length follows from them.

Top module: `frame_assembler`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the flag, address, data and byte count are cleared. After reset, `frame_rdy` is 0 and `frame_addr` and `frame_data` are 0.
- R2: A byte is taken at a clock edge only when `rx_cs` is 1 and `rx_wr` is 0. Any cycle with `rx_cs` at 0, or with `rx_wr` at 1, adds nothing to the frame.
- R3: Byte order is most significant first. The six accepted bytes fill `frame_addr[15:8]`, `frame_addr[7:0]`, `frame_data[31:24]`, `frame_data[23:16]`, `frame_data[15:8]` and `frame_data[7:0]`, in that order.
- R4: `frame_rdy` stays 0 after five accepted bytes. It is 1 right after the clock edge that accepts the sixth byte.
- R5: While `frame_rdy` is high, `frame_addr` and `frame_data` do not change.
- R6: While `frame_rdy` is high and `mem_ack` is 0, the flag stays high and qualified strobes are ignored; they do not count toward the next frame.
- R7: `mem_ack` at a clock edge where `frame_rdy` is high clears `frame_rdy` after that edge. `mem_ack` while `frame_rdy` is low has no effect on a partly collected frame.
- R8: If `mem_ack` and a qualified strobe arrive in the same cycle while `frame_rdy` is high, the byte is dropped.
- R9: A reset in the middle of a frame discards the bytes collected so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Byte read from the receive FIFO |
| rx_cs | input | 1 | Read-cycle chip-select strobe |
| rx_wr | input | 1 | Direction line: 1 for write, 0 for read |
| mem_ack | input | 1 | Memory side has taken the frame |
| frame_rdy | output | 1 | A complete frame is waiting to be written |
| frame_addr | output | 16 | Assembled address |
| frame_data | output | 32 | Assembled data word |

## Verification
Two functions can fall in the same cycle: releasing a pending frame through the acknowledge, and capturing a byte through a qualified strobe. The bench drives both in one cycle while the flag is high. It then sends a fresh six-byte frame. If the dropped byte had been captured, it would shift every byte of that frame by one place, so the bench compares the full address and data against the fresh values. The bench also sends an acknowledge in the middle of a partial frame and checks that the frame still completes intact.

// File: rtl/frame_assembler.sv
module frame_assembler #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte,
  input  logic              rx_cs,
  input  logic              rx_wr,
  input  logic              mem_ack,
  output logic              frame_rdy,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int NBYTES  = FRAME_W / 8;
  localparam int CNT_W   = $clog2(NBYTES);
  localparam int HOLD_W  = FRAME_W - 8;

  logic [HOLD_W-1:0] held;
  logic [CNT_W-1:0]  cnt;

  wire take = rx_cs & ~rx_wr & ~frame_rdy;
  wire last = (cnt == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      held       <= '0;
      frame_rdy  <= 1'b0;
      frame_addr <= '0;
      frame_data <= '0;
    end else begin
      if (frame_rdy && mem_ack)
        frame_rdy <= 1'b0;
      if (take) begin
        if (last) begin
          cnt                      <= '0;
          frame_rdy                <= 1'b1;
          {frame_addr, frame_data} <= {held, rx_byte};
        end else begin
          cnt  <= cnt + 1'b1;
          held <= {held[HOLD_W-9:0], rx_byte};
        end
      end
    end
  end
endmodule

// File: rtl/frame_assembler_chk.sv
module frame_assembler_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_cs,
  input logic              rx_wr,
  input logic              mem_ack,
  input logic              frame_rdy,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [DATA_W-1:0] frame_data
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!frame_rdy && frame_addr == '0 && frame_data == '0));

  // R4
  rise_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_rdy) |-> $past(rx_cs && !rx_wr));

  // R5
  outputs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_rdy && $past(frame_rdy)) |-> ($stable(frame_addr) && $stable(frame_data)));

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_rdy && !mem_ack) |=> frame_rdy);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_rdy && mem_ack) |=> !frame_rdy);
endmodule

bind frame_assembler frame_assembler_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_cs(rx_cs), .rx_wr(rx_wr), .mem_ack(mem_ack),
  .frame_rdy(frame_rdy), .frame_addr(frame_addr), .frame_data(frame_data)
);

// File: tb/tb_frame_assembler.sv
`timescale 1ns/1ps
module tb_frame_assembler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_byte = '0;
  logic        rx_cs = 1'b0;
  logic        rx_wr = 1'b0;
  logic        mem_ack = 1'b0;
  logic        frame_rdy;
  logic [15:0] frame_addr;
  logic [31:0] frame_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  frame_assembler dut (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_cs(rx_cs), .rx_wr(rx_wr),
    .mem_ack(mem_ack), .frame_rdy(frame_rdy), .frame_addr(frame_addr),
    .frame_data(frame_data)
  );

  localparam logic [47:0] FRAMES [4] = '{
    48'h1234_DEADBEEF, 48'hA5C3_00FF7E81, 48'h0001_80000001, 48'hFFFE_13579BDF
  };

  task automatic step(input logic [7:0] b, input logic cs, input logic wr, input logic ack);
    rx_byte = b; rx_cs = cs; rx_wr = wr; mem_ack = ack;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [48:0] act, input logic [48:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [47:0] f, input bit noisy, input bit mid_ack);
    for (int k = 0; k < 6; k++) begin
      if (noisy) begin
        step(8'hEE, 1'b1, 1'b1, 1'b0);
        step(8'hDD, 1'b0, 1'b0, 1'b0);
      end
      if (mid_ack && k == 3) step(8'hCC, 1'b0, 1'b0, 1'b1);
      step(f[47-8*k -: 8], 1'b1, 1'b0, 1'b0);
      if (k == 4) chk("R4 no flag after five bytes", {48'h0, frame_rdy}, 49'h0);
    end
    step(8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", {frame_rdy, frame_addr, frame_data}, 49'h0);

    for (int i = 0; i < 4; i++) begin
      logic [47:0] f;
      f = FRAMES[i];
      send_frame(f, (i % 2) == 1, i == 3);
      chk("R2 R3 frame content", {frame_rdy, frame_addr, frame_data}, {1'b1, f});
      step(8'h77, 1'b1, 1'b0, 1'b0);
      chk("R5 R6 held while pending", {frame_rdy, frame_addr, frame_data}, {1'b1, f});
      if (i == 1) step(8'h66, 1'b1, 1'b0, 1'b1);
      else        step(8'h00, 1'b0, 1'b0, 1'b1);
      chk("R7 ack clears flag", {48'h0, frame_rdy}, 49'h0);
    end

    send_frame(48'h4242_01020304, 1'b0, 1'b0);
    chk("R8 ack-time byte dropped", {frame_rdy, frame_addr, frame_data}, {1'b1, 48'h4242_01020304});
    step(8'h00, 1'b0, 1'b0, 1'b1);

    step(8'h99, 1'b1, 1'b0, 1'b0);
    step(8'h98, 1'b1, 1'b0, 1'b0);
    step(8'h97, 1'b1, 1'b0, 1'b0);
    rst = 1'b1;
    step(8'h00, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    chk("R1 R9 cleared by reset", {frame_rdy, frame_addr, frame_data}, 49'h0);
    send_frame(48'hBEEF_CAFEF00D, 1'b0, 1'b0);
    chk("R9 partial bytes discarded", {frame_rdy, frame_addr, frame_data}, {1'b1, 48'hBEEF_CAFEF00D});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule